// File: doc/BRIEF.md
# Multi-Scheme Hard-Decision Slicer

This block turns a stream of complex baseband samples into hard bit decisions. A two-bit scheme selector picks one of three constellations: binary phase shift keying, quadrature phase shift keying, or 16-point quadrature amplitude modulation. Each accepted sample is sliced into one, two or four bits. The bits then leave the block one per output beat, in a fixed order.

Samples arrive under a valid/ready handshake, each with a packet-start and a packet-end marker. Bits leave under a second valid/ready handshake. Each bit comes out as a small signed value of 0 or 1, with the markers placed beside it. The block stops accepting samples while it still has bits of the current symbol to send. This lets a downstream deinterleaver or decoder throttle the stream without any loss.

Top module: `hardDemod`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: modSel selects the scheme. 0 is binary (1 bit per symbol), 1 is quadrature phase (2 bits), 2 is 16-point (4 bits), and 3 acts like 0. The selector is sampled only in the cycle a symbol is accepted.
- R3: In binary mode the single bit is 1 when inI >= 0 (two's complement) and 0 otherwise. inQ has no effect on it.
- R4: In quadrature phase mode the first bit is 1 when inI >= 0, and the second bit is 1 when inQ >= 0.
- R5: In 16-point mode the bits leave in this order: I sign, I inner, Q sign, Q inner. A sign bit is 1 when the sample is >= 0. An inner bit is 1 when -QAM_TH < x < QAM_TH.
- R6: outBit is a signed BIT_W value that is always 0 or 1.
- R7: While outValid is high, inReady is low. inReady returns high in the cycle after the last bit of a symbol is taken.
- R8: outPktStart is high only on the first bit of a symbol accepted with inPktStart. outPktEnd is high only on the last bit of a symbol accepted with inPktEnd.
- R9: While outValid is high and outReady is low, outValid, outBit and both markers hold their values into the next cycle.
- R10: In the cycle after a symbol is accepted, outValid is high and the first bit of that symbol is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modSel | input | 2 | Scheme selector |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Block can accept a sample |
| inI | input | DATA_W | In-phase sample, signed |
| inQ | input | DATA_W | Quadrature sample, signed |
| inPktStart | input | 1 | Sample opens a packet |
| inPktEnd | input | 1 | Sample closes a packet |
| outValid | output | 1 | Output bit valid |
| outReady | input | 1 | Consumer takes the bit |
| outBit | output | BIT_W | Decided bit, signed 0 or 1 |
| outPktStart | output | 1 | First bit of a packet |
| outPktEnd | output | 1 | Last bit of a packet |

## Verification
The assertions check the handshake behaviour on every cycle. They confirm that a stalled output holds its bit and markers, that an accepted symbol produces a valid beat in the next cycle, that the input reopens right after the last bit is taken, and that the markers never appear without outValid. Only the bench scenarios can show that the slicing decisions are correct. They check the values at the exact 16-point threshold, at zero and at minus one, the bit order within a symbol, that inQ has no effect in binary mode, and that markers land on the right beats under steady, alternating and random backpressure.

// File: rtl/hardDemodPkg.sv
package hardDemodPkg;

  localparam int MAX_BITS = 4;
  localparam int CNT_W    = 3;

  typedef enum logic [1:0] {
    MOD_BIN  = 2'd0,
    MOD_QUAD = 2'd1,
    MOD_Q16  = 2'd2,
    MOD_BIN2 = 2'd3
  } modSel_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic firstBit;
    logic lastBit;
  } demodStrobes_t;

  function automatic logic [CNT_W-1:0] bitsPerSym(input logic [1:0] m);
    case (modSel_e'(m))
      MOD_QUAD: bitsPerSym = 3'd2;
      MOD_Q16:  bitsPerSym = 3'd4;
      default:  bitsPerSym = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/hardDemodCtrl.sv
module hardDemodCtrl
  import hardDemodPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    modSel,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output demodStrobes_t strobes
);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] bitIdx;
  logic             busy;

  assign busy     = (remain != '0);
  assign inReady  = !busy;
  assign outValid = busy;

  assign strobes.load     = inValid && inReady;
  assign strobes.shift    = outValid && outReady;
  assign strobes.firstBit = (bitIdx == '0);
  assign strobes.lastBit  = (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      bitIdx <= '0;
    end else if (strobes.load) begin
      remain <= bitsPerSym(modSel);
      bitIdx <= '0;
    end else if (strobes.shift) begin
      remain <= remain - CNT_W'(1);
      bitIdx <= bitIdx + CNT_W'(1);
    end
  end

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid && strobes.firstBit));

  // R7
  reopen_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && strobes.lastBit) |=> inReady);

endmodule

// File: rtl/hardDemodPath.sv
module hardDemodPath
  import hardDemodPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BIT_W  = 2,
  parameter int QAM_TH = 10362
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               modSel,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     inPktStart,
  input  logic                     inPktEnd,
  input  demodStrobes_t            strobes,
  output logic signed [BIT_W-1:0]  outBit,
  output logic                     outPktStart,
  output logic                     outPktEnd
);

  localparam logic signed [DATA_W-1:0] TH_POS = DATA_W'(QAM_TH);
  localparam logic signed [DATA_W-1:0] TH_NEG = -TH_POS;

  logic                iPos, qPos, iInner, qInner;
  logic [MAX_BITS-1:0] symBits;
  logic [MAX_BITS-1:0] shReg;
  logic                startReg, endReg;

  // Per-axis slicing; Gray mapping on each axis
  assign iPos   = !inI[DATA_W-1];
  assign qPos   = !inQ[DATA_W-1];
  assign iInner = (inI < TH_POS) && (inI > TH_NEG);
  assign qInner = (inQ < TH_POS) && (inQ > TH_NEG);

  // Bit 0 leaves first
  always_comb begin
    case (modSel_e'(modSel))
      MOD_QUAD: symBits = {2'b00, qPos, iPos};
      MOD_Q16:  symBits = {qInner, qPos, iInner, iPos};
      default:  symBits = {3'b000, iPos};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      startReg <= 1'b0;
      endReg   <= 1'b0;
    end else if (strobes.load) begin
      shReg    <= symBits;
      startReg <= inPktStart;
      endReg   <= inPktEnd;
    end else if (strobes.shift) begin
      shReg    <= shReg >> 1;
    end
  end

  assign outBit      = {{(BIT_W-1){1'b0}}, shReg[0]};
  assign outPktStart = startReg && strobes.firstBit;
  assign outPktEnd   = endReg && strobes.lastBit;

endmodule

// File: rtl/hardDemod.sv
module hardDemod
  import hardDemodPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BIT_W  = 2,
  parameter int QAM_TH = 10362
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               modSel,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     inPktStart,
  input  logic                     inPktEnd,
  output logic                     outValid,
  input  logic                     outReady,
  output logic signed [BIT_W-1:0]  outBit,
  output logic                     outPktStart,
  output logic                     outPktEnd
);

  demodStrobes_t strobes;

  hardDemodCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .modSel   (modSel),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  hardDemodPath #(
    .DATA_W (DATA_W),
    .BIT_W  (BIT_W),
    .QAM_TH (QAM_TH)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .modSel      (modSel),
    .inI         (inI),
    .inQ         (inQ),
    .inPktStart  (inPktStart),
    .inPktEnd    (inPktEnd),
    .strobes     (strobes),
    .outBit      (outBit),
    .outPktStart (outPktStart),
    .outPktEnd   (outPktEnd)
  );

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outBit) &&
                                 $stable(outPktStart) && $stable(outPktEnd)));

  // R8
  start_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outPktStart |-> outValid);

  // R8
  end_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outPktEnd |-> outValid);

  // R6
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outBit == BIT_W'(0) || outBit == BIT_W'(1)));

endmodule

// File: tb/tb_hardDemod.sv
module tb_hardDemod;

  localparam int DATA_W = 16;
  localparam int BIT_W  = 2;
  localparam int TH     = 10362;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modSel = 2'd0;
  logic inValid = 1'b0;
  logic inReady;
  logic signed [DATA_W-1:0] inI = '0;
  logic signed [DATA_W-1:0] inQ = '0;
  logic inPktStart = 1'b0;
  logic inPktEnd = 1'b0;
  logic outValid;
  logic outReady;
  logic signed [BIT_W-1:0] outBit;
  logic outPktStart, outPktEnd;

  always #2 clk = ~clk;

  hardDemod #(.DATA_W(DATA_W), .BIT_W(BIT_W), .QAM_TH(TH)) dut (
    .clk(clk), .rstN(rstN), .modSel(modSel), .inValid(inValid), .inReady(inReady),
    .inI(inI), .inQ(inQ), .inPktStart(inPktStart), .inPktEnd(inPktEnd),
    .outValid(outValid), .outReady(outReady), .outBit(outBit),
    .outPktStart(outPktStart), .outPktEnd(outPktEnd)
  );

  typedef struct {
    bit    b;
    bit    s;
    bit    e;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  int readyMode = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void pushSym(input logic [1:0] m, input int i, input int q,
                                  input bit s, input bit e, input string tag);
    bit bits[4];
    int n;
    bits[0] = (i >= 0);
    case (m)
      2'd1: begin n = 2; bits[1] = (q >= 0); end
      2'd2: begin
        n = 4;
        bits[1] = (i < TH) && (i > -TH);
        bits[2] = (q >= 0);
        bits[3] = (q < TH) && (q > -TH);
      end
      default: n = 1;
    endcase
    for (int k = 0; k < n; k++) begin
      expItem_t it;
      it.b = bits[k];
      it.s = s && (k == 0);
      it.e = e && (k == n - 1);
      it.tag = tag;
      expQ.push_back(it);
    end
  endfunction

  task automatic sendSym(input logic [1:0] m, input int i, input int q,
                         input bit s, input bit e, input string tag);
    @(negedge clk);
    modSel = m;
    inI = DATA_W'(i);
    inQ = DATA_W'(q);
    inPktStart = s;
    inPktEnd = e;
    inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    pushSym(m, i, q, s, e, tag);
    @(posedge clk);
    #1;
    inValid = 1'b0;
    // R10: first bit presented one cycle after acceptance
    check(outValid == 1'b1, "R10", "outValid after accept", int'(outValid), 1);
    // R2: selector changes after acceptance must not matter
    modSel = ~m;
    inI = -inI;
  endtask

  // Monitor / scoreboard
  initial begin
    bit prevStall = 0;
    logic signed [BIT_W-1:0] savBit;
    bit savS, savE;
    outReady = 1'b0;
    forever begin
      @(negedge clk);
      case (readyMode)
        0: outReady = 1'b1;
        1: outReady = ~outReady;
        default: outReady = (($urandom % 3) != 0);
      endcase
      #1;
      if (rstN) begin
        if (prevStall) begin
          check(outValid && outBit == savBit && outPktStart == savS && outPktEnd == savE,
                "R9", "stalled beat held", int'(outBit), int'(savBit));
        end
        if (outValid) begin
          check(!inReady, "R7", "inReady while bits remain", int'(inReady), 0);
          check(outBit == 0 || outBit == 1, "R6", "outBit range", int'(outBit), 1);
        end
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R2", "unexpected extra bit", int'(outBit), -1);
          end else begin
            expItem_t it;
            it = expQ.pop_front();
            check(outBit == BIT_W'(it.b), it.tag, "bit value", int'(outBit), int'(it.b));
            check(outPktStart == it.s, "R8", "start marker", int'(outPktStart), int'(it.s));
            check(outPktEnd == it.e, "R8", "end marker", int'(outPktEnd), int'(it.e));
          end
        end
        prevStall = outValid && !outReady;
        savBit = outBit;
        savS = outPktStart;
        savE = outPktEnd;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);

    // R3: binary, Q must not matter
    readyMode = 0;
    sendSym(2'd0, 0, -500, 1, 0, "R3");
    sendSym(2'd0, -1, 700, 0, 0, "R3");
    sendSym(2'd0, 32767, -32768, 0, 0, "R3");
    sendSym(2'd0, -32768, 32767, 0, 1, "R3");

    // R4: quadrature phase, alternating backpressure
    readyMode = 1;
    sendSym(2'd1, 100, -100, 1, 0, "R4");
    sendSym(2'd1, -100, 100, 0, 0, "R4");
    sendSym(2'd1, 0, -1, 0, 0, "R4");
    sendSym(2'd1, -1, 0, 0, 1, "R4");

    // R5: 16-point thresholds under random backpressure
    readyMode = 2;
    sendSym(2'd2, TH, -TH, 1, 0, "R5");
    sendSym(2'd2, TH - 1, -TH + 1, 0, 0, "R5");
    sendSym(2'd2, 0, -1, 0, 0, "R5");
    sendSym(2'd2, -30000, 30000, 0, 0, "R5");
    sendSym(2'd2, -TH - 1, TH + 1, 1, 1, "R5");

    // R2: selector value 3 acts as binary
    sendSym(2'd3, 5, -5, 1, 0, "R2");
    sendSym(2'd3, -5, 5, 0, 1, "R2");

    // Mixed schemes back to back
    readyMode = 1;
    sendSym(2'd2, 20000, 3, 1, 0, "R5");
    sendSym(2'd0, -7, 0, 0, 0, "R3");
    sendSym(2'd1, 9, 9, 0, 1, "R4");

    for (int w = 0; w < 200 && (expQ.size() != 0 || outValid); w++) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R2", "bits outstanding", expQ.size(), 0);
    check(inReady == 1'b1, "R7", "inReady when drained", int'(inReady), 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule